// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits between a group of lanes and a shared scratchpad built from single-ported banks holding 32-bit words. A whole request vector arrives at once: each lane carries an active flag, a write flag, a word address and write data. The bank that serves a word is its address modulo the bank count, which is the low five bits for 32 banks. The remaining upper bits select the row inside that bank. Lanes that land in the same bank on different words conflict and must be served in separate passes. Lanes that name the same word share one access.

The arbiter splits the request into the smallest number of conflict-free passes and drives one pass per cycle onto the bank ports. It holds `stall` high while further passes remain. When the last pass is done it returns every lane's data together, with the number of passes the request needed.

The request side is valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a cycle with `req_valid` and `req_ready` both high. The response side is also valid/ready. Once `rsp_valid` rises, the response holds steady until `rsp_ready` is seen, and no new request is taken before that handshake. The bank side has no handshake. A bank with `bank_en` high must read or write the addressed row in that cycle, and its read data is taken from `bank_rdata` in the same cycle.

Top module: `sp_conflict_arb`

## Requirements
- R1: A lane's bank is bits [4:0] of its word address, and the row driven on that bank's `bank_row` slice is the address shifted right by five. Only banks that hold a pending lane see `bank_en` high, so addresses 32 words apart share a bank.
- R2: When lane i uses address base+i for every lane, the request completes in a single pass. `rsp_ways` is 1 and `stall` never rises.
- R3: With 32 active lanes, a lane stride of 2 words gives `rsp_ways` = 2 and a lane stride of 8 words gives `rsp_ways` = 8.
- R4: Any mapping of lanes onto 32 distinct banks, in any lane order, completes in one pass.
- R5: If lane i walks a column with row length 32 (address 32*i), the request needs 32 passes. With the row padded to 33 words (address 33*i), it needs one pass.
- R6: `rsp_ways` equals the largest number of distinct word addresses that the active lanes place in any one bank. `stall` is high for exactly `rsp_ways` minus one cycles of the request, and for none when `rsp_ways` is 0 or 1.
- R7: All active lanes that name the same word are served in the same pass. Each reading lane among them receives that word.
- R8: Inside one bank, the word named by the lowest-numbered pending lane is accessed first.
- R9: When several active lanes write the same word, the data from the highest-numbered writer is stored. Every active lane on that word, reader or writer, returns the stored value.
- R10: An inactive lane causes no bank access and writes nothing, whatever its flags are. Its `rsp_rdata` slice is 0.
- R11: `req_ready` is high only when the block is idle. `rsp_valid`, `rsp_ways` and `rsp_rdata` stay unchanged while `rsp_ready` is low. A request with no active lane gives a response with `rsp_ways` = 0 and touches no bank.
- R12: For a pass that contains a write to a word, the arbiter drives `bank_we` high on that bank together with the winning write data on `bank_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request vector offered |
| req_ready | output | 1 | Arbiter idle and able to take a request |
| req_active | input | LANES | Per-lane active flag |
| req_we | input | LANES | Per-lane write flag |
| req_addr | input | LANES*ADDR_W | Per-lane word address, lane 0 in the low bits |
| req_wdata | input | LANES*DATA_W | Per-lane write data |
| stall | output | 1 | More passes follow the current one |
| bank_en | output | BANKS | Per-bank access enable |
| bank_we | output | BANKS | Per-bank write enable |
| bank_row | output | BANKS*(ADDR_W-5) | Per-bank row select |
| bank_wdata | output | BANKS*DATA_W | Per-bank write data |
| bank_rdata | input | BANKS*DATA_W | Per-bank read data, valid in the cycle of access |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ways | output | $clog2(LANES+1) | Passes the request needed |
| rsp_rdata | output | LANES*DATA_W | Per-lane returned word |

## Verification
The arbiter is driven with several address patterns. Unit stride, a distinct-bank permutation and a 33-word padded column should each take one pass. Strides of 2 and 8 and a 32-word column walk should take 2, 8 and 32 passes, which separates a correct modulo-bank decode from one that under-counts or over-counts conflicts. Patterns where many lanes share one word, and a bank that mixes shared and private words, separate broadcast grouping from plain serialisation. Duplicate writes with a reader on the same word expose the winner rule and the value the reader sees. A three-lane, single-bank case watched on the bank port fixes the service order. Inactive lanes with stale write flags, an empty request, and a response held under back-pressure cover the remaining edge behaviour.

// File: rtl/sp_arb_pkg.sv
package sp_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } arb_state_e;
endpackage

// File: rtl/sp_bank_pick.sv
// Chooses the word one bank serves in the current pass: the word named by the
// lowest pending lane in this bank. Grants every pending lane on that word and
// merges their writes, with the highest lane winning.
module sp_bank_pick #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int BANK_W  = 5,
  parameter int BANK_ID = 0
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*DATA_W-1:0] lane_wdata,
  output logic [LANES-1:0]        grant,
  output logic                    acc_en,
  output logic                    acc_we,
  output logic [ADDR_W-BANK_W-1:0] acc_row,
  output logic [DATA_W-1:0]       acc_wdata
);
  localparam logic [BANK_W-1:0] MY_BANK = BANK_ID[BANK_W-1:0];

  logic [LANES-1:0]  hit;
  logic [ADDR_W-1:0] lead;

  always_comb begin
    hit    = '0;
    lead   = '0;
    acc_en = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      hit[l] = pend[l] && (lane_addr[l*ADDR_W +: BANK_W] == MY_BANK);
      if (hit[l] && !acc_en) begin
        acc_en = 1'b1;
        lead   = lane_addr[l*ADDR_W +: ADDR_W];
      end
    end
  end

  always_comb begin
    grant     = '0;
    acc_we    = 1'b0;
    acc_wdata = '0;
    for (int l = 0; l < LANES; l++) begin
      grant[l] = hit[l] && (lane_addr[l*ADDR_W +: ADDR_W] == lead);
      if (grant[l] && lane_we[l]) begin
        acc_we    = 1'b1;
        acc_wdata = lane_wdata[l*DATA_W +: DATA_W];
      end
    end
  end

  assign acc_row = lead[ADDR_W-1:BANK_W];
endmodule

// File: rtl/sp_result_gather.sv
// Per-lane result registers: cleared on accept, loaded when the lane is served.
module sp_result_gather #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int DATA_W = 32,
  parameter int BANK_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    capture,
  input  logic [LANES-1:0]        served,
  input  logic [LANES*BANK_W-1:0] lane_bank,
  input  logic [BANKS*DATA_W-1:0] bank_rdata,
  input  logic [BANKS-1:0]        fwd_we,
  input  logic [BANKS*DATA_W-1:0] fwd_wdata,
  output logic [LANES*DATA_W-1:0] lane_result
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BANK_W-1:0] bsel;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] res_q;

    assign bsel = lane_bank[l*BANK_W +: BANK_W];

    always_comb begin
      if (fwd_we[bsel]) word = fwd_wdata[int'(bsel)*DATA_W +: DATA_W];
      else              word = bank_rdata[int'(bsel)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     res_q <= '0;
      else if (clear)                 res_q <= '0;
      else if (capture && served[l])  res_q <= word;
    end

    assign lane_result[l*DATA_W +: DATA_W] = res_q;

    // R10: a lane cleared at accept and never served keeps a zero result
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (res_q == '0));
  end
endmodule

// File: rtl/sp_pass_ctrl.sv
// Sequencer: idle -> passes -> response held until taken.
module sp_pass_ctrl
  import sp_arb_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int WAYS_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              any_active,
  input  logic              more_pending,
  input  logic              rsp_ready,
  output logic              req_ready,
  output logic              accept,
  output logic              running,
  output logic              stall,
  output logic              rsp_valid,
  output logic [WAYS_W-1:0] ways
);
  arb_state_e state_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign running   = (state_q == ST_RUN);
  assign stall     = running && more_pending;
  assign rsp_valid = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ways    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          ways    <= '0;
          state_q <= any_active ? ST_RUN : ST_DONE;
        end
        ST_RUN: begin
          ways <= ways + 1'b1;
          if (!more_pending) state_q <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: stall only while passes are being issued
  p_stall_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (state_q == ST_RUN));
  // R11: the response stays put under back-pressure
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(ways)));
  // R11: after the response is taken the arbiter is idle again
  p_idle_after_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);
endmodule

// File: rtl/sp_conflict_arb.sv
module sp_conflict_arb
  import sp_arb_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [LANES-1:0]                      req_active,
  input  logic [LANES-1:0]                      req_we,
  input  logic [LANES*ADDR_W-1:0]               req_addr,
  input  logic [LANES*DATA_W-1:0]               req_wdata,
  output logic                                  stall,
  output logic [BANKS-1:0]                      bank_en,
  output logic [BANKS-1:0]                      bank_we,
  output logic [BANKS*(ADDR_W-$clog2(BANKS))-1:0] bank_row,
  output logic [BANKS*DATA_W-1:0]               bank_wdata,
  input  logic [BANKS*DATA_W-1:0]               bank_rdata,
  output logic                                  rsp_valid,
  input  logic                                  rsp_ready,
  output logic [$clog2(LANES+1)-1:0]            rsp_ways,
  output logic [LANES*DATA_W-1:0]               rsp_rdata
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int WAYS_W = $clog2(LANES + 1);

  logic                    accept, running;
  logic [LANES-1:0]        pend_q, served, more_mask;
  logic [LANES-1:0]        we_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*DATA_W-1:0] wdata_q;
  logic [LANES*BANK_W-1:0] lane_bank;
  logic [BANKS-1:0]        pick_en, pick_we;
  logic [BANKS*DATA_W-1:0] pick_wdata;
  logic [LANES-1:0]        grant [BANKS];

  // Request capture and pending-lane tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      we_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      pend_q  <= req_active;
      we_q    <= req_we;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end else if (running) begin
      pend_q  <= pend_q & ~served;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lbank
    assign lane_bank[l*BANK_W +: BANK_W] = addr_q[l*ADDR_W +: BANK_W];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sp_bank_pick #(
      .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .BANK_W(BANK_W), .BANK_ID(b)
    ) u_pick (
      .pend      (pend_q),
      .lane_addr (addr_q),
      .lane_we   (we_q),
      .lane_wdata(wdata_q),
      .grant     (grant[b]),
      .acc_en    (pick_en[b]),
      .acc_we    (pick_we[b]),
      .acc_row   (bank_row[b*ROW_W +: ROW_W]),
      .acc_wdata (pick_wdata[b*DATA_W +: DATA_W])
    );
    assign bank_en[b] = pick_en[b] && running;
    assign bank_we[b] = pick_we[b] && running;
  end

  assign bank_wdata = pick_wdata;

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | grant[b];
  end

  assign more_mask = pend_q & ~served;

  sp_pass_ctrl #(.LANES(LANES), .WAYS_W(WAYS_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .any_active  (|req_active),
    .more_pending(|more_mask),
    .rsp_ready   (rsp_ready),
    .req_ready   (req_ready),
    .accept      (accept),
    .running     (running),
    .stall       (stall),
    .rsp_valid   (rsp_valid),
    .ways        (rsp_ways)
  );

  sp_result_gather #(
    .LANES(LANES), .BANKS(BANKS), .DATA_W(DATA_W), .BANK_W(BANK_W)
  ) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept),
    .capture    (running),
    .served     (served),
    .lane_bank  (lane_bank),
    .bank_rdata (bank_rdata),
    .fwd_we     (pick_we),
    .fwd_wdata  (pick_wdata),
    .lane_result(rsp_rdata)
  );

  // R6: each issued pass retires at least one lane
  p_progress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (served != '0));
  // R6: pass count never exceeds the lane count
  p_ways_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_ways <= WAYS_W'(LANES)));
  // R11: returned data is stable under back-pressure
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(rsp_rdata));
  // R10: no lane is left pending once the arbiter is idle
  p_idle_no_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pend_q == '0));
  // R1: bank access only while passes are issued
  p_bank_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (bank_en == '0));
endmodule

// File: tb/sp_conflict_arb_tb.sv
`timescale 1ns/1ps
module sp_conflict_arb_tb;
  localparam int LANES  = 32;
  localparam int BANKS  = 32;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ROW_W  = ADDR_W - 5;
  localparam int WAYS_W = $clog2(LANES + 1);
  localparam int WORDS  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic [LANES-1:0]        req_active = '0;
  logic [LANES-1:0]        req_we = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES*DATA_W-1:0] req_wdata = '0;
  logic                    stall;
  logic [BANKS-1:0]        bank_en, bank_we;
  logic [BANKS*ROW_W-1:0]  bank_row;
  logic [BANKS*DATA_W-1:0] bank_wdata, bank_rdata;
  logic                    rsp_valid;
  logic                    rsp_ready = 1'b1;
  logic [WAYS_W-1:0]       rsp_ways;
  logic [LANES*DATA_W-1:0] rsp_rdata;

  sp_conflict_arb #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_active(req_active), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .stall(stall), .bank_en(bank_en), .bank_we(bank_we), .bank_row(bank_row),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ways(rsp_ways), .rsp_rdata(rsp_rdata)
  );

  // Bank storage model and independent reference copy
  logic [DATA_W-1:0] bank_mem [WORDS];
  logic [DATA_W-1:0] ref_mem  [WORDS];
  initial for (int i = 0; i < WORDS; i++) begin
    bank_mem[i] = DATA_W'(i * 3 + 7);
    ref_mem[i]  = DATA_W'(i * 3 + 7);
  end

  always_comb
    for (int b = 0; b < BANKS; b++)
      bank_rdata[b*DATA_W +: DATA_W] = bank_mem[int'(bank_row[b*ROW_W +: ROW_W]) * BANKS + b];

  always @(posedge clk)
    for (int b = 0; b < BANKS; b++)
      if (bank_en[b] && bank_we[b])
        bank_mem[int'(bank_row[b*ROW_W +: ROW_W]) * BANKS + b] <= bank_wdata[b*DATA_W +: DATA_W];

  int n_vec = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Stimulus staging
  logic [LANES-1:0]  t_act, t_we;
  logic [ADDR_W-1:0] t_addr  [LANES];
  logic [DATA_W-1:0] t_wdata [LANES];

  logic [LANES*DATA_W-1:0] q_rd   [$];
  int                      q_ways [$];
  string                   q_tag  [$];

  task automatic clear_stage();
    t_act = '0;
    t_we  = '0;
    for (int l = 0; l < LANES; l++) begin
      t_addr[l]  = '0;
      t_wdata[l] = '0;
    end
  endtask

  // Driver: builds the expectation, then offers the request.
  // Returns at the negedge after acceptance (first pass visible there).
  task automatic send(input string tag);
    logic [LANES*DATA_W-1:0] exp_rd;
    int cnt [BANKS];
    int ways;
    exp_rd = '0;
    ways = 0;
    for (int b = 0; b < BANKS; b++) cnt[b] = 0;
    for (int l = 0; l < LANES; l++) begin
      if (t_act[l]) begin
        logic [DATA_W-1:0] v;
        bit first;
        v = ref_mem[t_addr[l]];
        for (int m = 0; m < LANES; m++)
          if (t_act[m] && t_we[m] && t_addr[m] == t_addr[l]) v = t_wdata[m];
        exp_rd[l*DATA_W +: DATA_W] = v;
        first = 1'b1;
        for (int k = 0; k < l; k++)
          if (t_act[k] && t_addr[k] == t_addr[l]) first = 1'b0;
        if (first) cnt[t_addr[l][4:0]]++;
      end
    end
    for (int b = 0; b < BANKS; b++) if (cnt[b] > ways) ways = cnt[b];
    for (int l = 0; l < LANES; l++)
      if (t_act[l] && t_we[l]) ref_mem[t_addr[l]] = t_wdata[l];
    q_rd.push_back(exp_rd);
    q_ways.push_back(ways);
    q_tag.push_back(tag);

    @(negedge clk);
    req_active = t_act;
    req_we     = t_we;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*ADDR_W +: ADDR_W]  = t_addr[l];
      req_wdata[l*DATA_W +: DATA_W] = t_wdata[l];
    end
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  int stall_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall) stall_cnt++;
      if (rsp_valid && rsp_ready) begin
        if (q_ways.size() == 0) begin
          chk(1'b0, "R11 unexpected response", 64'(rsp_ways), 0);
        end else begin
          logic [LANES*DATA_W-1:0] e;
          int ew, bad_l;
          string tg;
          e  = q_rd.pop_front();
          ew = q_ways.pop_front();
          tg = q_tag.pop_front();
          chk(rsp_ways == WAYS_W'(ew), {tg, " ways"}, 64'(rsp_ways), 64'(ew));
          chk(stall_cnt == ((ew > 1) ? ew - 1 : 0), {"R6 stall cycles ", tg},
              64'(stall_cnt), 64'((ew > 1) ? ew - 1 : 0));
          bad_l = -1;
          for (int l = LANES - 1; l >= 0; l--)
            if (rsp_rdata[l*DATA_W +: DATA_W] !== e[l*DATA_W +: DATA_W]) bad_l = l;
          if (bad_l < 0) chk(1'b1, {tg, " data"}, 0, 0);
          else chk(1'b0, $sformatf("%s data lane %0d", tg, bad_l),
                   64'(rsp_rdata[bad_l*DATA_W +: DATA_W]), 64'(e[bad_l*DATA_W +: DATA_W]));
        end
        stall_cnt = 0;
      end
    end
  end

  task automatic drain();
    int guard = 0;
    while (q_ways.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic run_tests();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 reset idle", {62'd0, req_ready, rsp_valid}, 64'h2);
    chk(stall == 1'b0 && bank_en == '0, "R1 reset quiet", 64'(bank_en), 0);

    // R2 / R12: unit-stride writes
    clear_stage();
    for (int l = 0; l < LANES; l++) begin
      t_act[l] = 1'b1; t_we[l] = 1'b1;
      t_addr[l] = ADDR_W'(l); t_wdata[l] = DATA_W'(32'h1000 + l);
    end
    send("R2 unit-stride write");
    chk(bank_we == '1, "R12 write enables", 64'(bank_we), 64'hFFFFFFFF);
    chk(bank_wdata[3*DATA_W +: DATA_W] == 32'h1003, "R12 write data bank3",
        64'(bank_wdata[3*DATA_W +: DATA_W]), 64'h1003);
    drain();

    // R2: unit-stride read back at an offset base
    clear_stage();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(l + 5); end
    send("R2 unit-stride read");
    drain();

    // R3: stride 2 and stride 8
    clear_stage();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(2 * l); end
    send("R3 stride2");
    drain();
    clear_stage();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(8 * l + 1); end
    send("R3 stride8");
    drain();

    // R4: permutation onto distinct banks
    clear_stage();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(((l * 7) % 32) + 640); end
    send("R4 permutation");
    drain();

    // R5: column walk, unpadded and padded
    clear_stage();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(32 * l + 2); end
    send("R5 column32");
    drain();
    clear_stage();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(33 * l + 2); end
    send("R5 column33");
    drain();

    // R7: broadcast of one word
    clear_stage();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(5); end
    send("R7 broadcast");
    drain();

    // R6 / R7: one bank with two shared words plus a private word
    clear_stage();
    for (int l = 0; l < 4; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(100); end
    for (int l = 4; l < 8; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(132); end
    t_act[9] = 1'b1; t_addr[9] = ADDR_W'(164);
    t_act[10] = 1'b1; t_addr[10] = ADDR_W'(11);
    send("R6 grouped bank");
    drain();

    // R9 / R10: duplicate writers, a reader, and inactive lanes with write flags
    clear_stage();
    t_act[2] = 1'b1; t_we[2] = 1'b1; t_addr[2] = ADDR_W'(200); t_wdata[2] = 32'hAAAA0002;
    t_act[9] = 1'b1; t_we[9] = 1'b1; t_addr[9] = ADDR_W'(200); t_wdata[9] = 32'hBBBB0009;
    t_act[4] = 1'b1; t_addr[4] = ADDR_W'(200);
    t_we[12] = 1'b1; t_addr[12] = ADDR_W'(300); t_wdata[12] = 32'hDEAD0012;
    t_we[20] = 1'b1; t_addr[20] = ADDR_W'(301); t_wdata[20] = 32'hDEAD0020;
    send("R9 duplicate write");
    chk(bank_en == (32'h1 << 8), "R10 only bank 8 enabled", 64'(bank_en), 64'h100);
    drain();
    clear_stage();
    t_act[0] = 1'b1; t_addr[0] = ADDR_W'(200);
    t_act[1] = 1'b1; t_addr[1] = ADDR_W'(300);
    t_act[2] = 1'b1; t_addr[2] = ADDR_W'(301);
    send("R10 readback after ignored lanes");
    drain();

    // R8 / R1: service order within one bank
    clear_stage();
    t_act[1] = 1'b1; t_addr[1] = ADDR_W'(69);
    t_act[3] = 1'b1; t_addr[3] = ADDR_W'(37);
    t_act[5] = 1'b1; t_addr[5] = ADDR_W'(5);
    send("R8 order");
    chk(bank_en == (32'h1 << 5), "R1 bank from low bits", 64'(bank_en), 64'h20);
    chk(bank_row[5*ROW_W +: ROW_W] == 7'd2, "R8 first pass row", 64'(bank_row[5*ROW_W +: ROW_W]), 2);
    chk(stall == 1'b1, "R6 stall in first of three passes", 64'(stall), 1);
    @(negedge clk);
    chk(bank_row[5*ROW_W +: ROW_W] == 7'd1, "R8 second pass row", 64'(bank_row[5*ROW_W +: ROW_W]), 1);
    drain();

    // R11: empty request
    clear_stage();
    t_we[7] = 1'b1; t_addr[7] = ADDR_W'(9); t_wdata[7] = 32'h77;
    send("R11 empty request");
    chk(bank_en == '0, "R11 empty touches no bank", 64'(bank_en), 0);
    drain();

    // R11: back-pressure on the response
    @(posedge clk); #1 rsp_ready = 1'b0;
    clear_stage();
    for (int l = 0; l < LANES; l++) begin t_act[l] = 1'b1; t_addr[l] = ADDR_W'(4 * l); end
    send("R11 back-pressure");
    repeat (6) @(negedge clk);
    chk(rsp_valid == 1'b1, "R11 rsp held", 64'(rsp_valid), 1);
    chk(req_ready == 1'b0, "R11 no accept while rsp pending", 64'(req_ready), 0);
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain();
    chk(q_ways.size() == 0, "R11 all responses seen", 64'(q_ways.size()), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule